// File: doc/BRIEF.md
# Two-Phase Shared-Port I/O Expander

This block time-shares one 8-bit open-collector port between two banks of outputs and two banks of inputs. A phase signal toggles every programmable number of clock cycles. While the phase signal is low the port carries output bank A (points 1..8); while it is high it carries output bank B (points 9..16). Board latches capture the port on each phase edge, so a single set of pins serves sixteen latched outputs. The pins are modelled as a drive-enable vector (a 1 pulls the pin to ground) and a sense vector (the pin level as seen on the board).

The block also captures inputs. Because the port is wired-OR, a pin reads low when either the block or something outside pulls it, and a low pin counts as an active input. A separate 8-bit active-low input port is read in the low phase as one bank and, when expansion is enabled, in the high phase as a second bank. Two configuration bits decide whether bank B outputs are presented, whether the shared port is sampled as inputs, and whether the second dedicated-input bank is read.

Drive changes are held off for a guard interval after each phase edge so that board latches see stable data around the edge, and all input sampling happens in the last cycle of a phase.

Top module: `mux_io_expander`

## Requirements
- R1: After reset `phase` is 0 and it toggles every PHASE_CYCLES clock cycles, starting with a low phase of PHASE_CYCLES cycles.
- R2: A `pin_drive` bit equal to 1 means the pin is pulled to ground, 0 means released. In the low phase the drive is `out_a`; in the high phase it is `out_b` when `cfg_bidir` or `cfg_expand` is 1, and all zeros otherwise.
- R3: `pin_drive` changes only on the clock edge at which the phase counter equals GUARD_CYCLES, so the new bank appears GUARD_CYCLES+1 cycles after the phase edge; before that the previous bank is held.
- R4: When `cfg_bidir` is 1, `in_a` takes the inverted `pin_sense` at the edge that ends a low phase and `in_b` takes it at the edge that ends a high phase; when `cfg_bidir` is 0 both hold their values.
- R5: `in_ded_a` takes the inverted `ded_n` at the edge that ends every low phase.
- R6: When `cfg_expand` is 1, `in_ded_b` takes the inverted `ded_n` at the edge that ends a high phase; otherwise it holds.
- R7: The value a board latch captures on a phase edge is the OR of that bank's drive and the external pull-downs, and the same OR is what `in_a`/`in_b` report.
- R8: While `rst_n` is 0 all outputs are 0 (phase low, all pins released, all input banks cleared).
- R9: An output bit written 0 does not mask its input: an external pull-down on that pin still reads as input 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bidir | input | 1 | Shared port sampled as inputs; bank B outputs presented |
| cfg_expand | input | 1 | Second dedicated-input bank read; bank B outputs presented |
| out_a | input | 8 | Output points 1..8, 1 = active |
| out_b | input | 8 | Output points 9..16, 1 = active |
| pin_sense | input | 8 | Level of each shared pin (0 = pulled low) |
| ded_n | input | 8 | Dedicated active-low input port |
| phase | output | 1 | Phase signal for board latches and muxes |
| pin_drive | output | 8 | 1 pulls the shared pin to ground |
| in_a | output | 8 | Input points 1..8 from the shared port |
| in_b | output | 8 | Input points 9..16 from the shared port |
| in_ded_a | output | 8 | Dedicated inputs, low-phase bank |
| in_ded_b | output | 8 | Dedicated inputs, high-phase bank |

## Verification
The bench aims at the phase boundaries: a design that switched drive on the phase edge instead of after the guard would make the board latch capture the wrong bank, and one that sampled a cycle early or late would swap bank A and bank B inputs. Each of the four configuration combinations is run, so a wrong map shows up as bank B presented when it should be released, or as the second dedicated bank moving when expansion is off. External pull-downs are applied on pins whose output bit is 0 and on pins already driven, which exposes a design that masks inputs with its own outputs or fails to OR them.

// File: rtl/mux_io_expander.sv
module mux_io_expander #(
  parameter int PHASE_CYCLES = 8,
  parameter int GUARD_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_bidir,
  input  logic       cfg_expand,
  input  logic [7:0] out_a,
  input  logic [7:0] out_b,
  input  logic [7:0] pin_sense,
  input  logic [7:0] ded_n,
  output logic       phase,
  output logic [7:0] pin_drive,
  output logic [7:0] in_a,
  output logic [7:0] in_b,
  output logic [7:0] in_ded_a,
  output logic [7:0] in_ded_b
);
  localparam int CW = (PHASE_CYCLES > 2) ? $clog2(PHASE_CYCLES) : 1;

  logic [CW-1:0] cnt;

  wire       last      = (cnt == CW'(PHASE_CYCLES - 1));
  wire       guard_hit = (cnt == CW'(GUARD_CYCLES));
  wire       b_en      = cfg_bidir | cfg_expand;
  wire [7:0] next_drv  = phase ? (b_en ? out_b : 8'h00) : out_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      phase     <= 1'b0;
      pin_drive <= 8'h00;
      in_a      <= 8'h00;
      in_b      <= 8'h00;
      in_ded_a  <= 8'h00;
      in_ded_b  <= 8'h00;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (guard_hit) pin_drive <= next_drv;
      if (last) begin
        phase <= ~phase;
        if (!phase) begin
          if (cfg_bidir) in_a <= ~pin_sense;
          in_ded_a <= ~ded_n;
        end else begin
          if (cfg_bidir)  in_b     <= ~pin_sense;
          if (cfg_expand) in_ded_b <= ~ded_n;
        end
      end
    end
  end

  a_r3_drive_after_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_drive) |-> $past(cnt) == CW'(GUARD_CYCLES));

  a_r4_in_a_at_phase_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_a) |-> ($rose(phase) && $past(cfg_bidir)));

  a_r4_in_b_at_phase_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_b) |-> ($fell(phase) && $past(cfg_bidir)));

  a_r5_ded_a_at_phase_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ded_a) |-> $rose(phase));

  a_r6_ded_b_needs_expand: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(in_ded_b) |-> ($fell(phase) && $past(cfg_expand)));

  a_r2_bank_b_released: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) && phase && $past(cnt) == CW'(GUARD_CYCLES) && !$past(cfg_bidir) && !$past(cfg_expand))
      |-> pin_drive == 8'h00);

  a_r1_phase_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase) |-> $past(cnt) == CW'(PHASE_CYCLES - 1));
endmodule

// File: tb/mux_io_expander_test.sv
module mux_io_expander_test;
  localparam int CLK_NS = 10;
  localparam int PH = 8;
  localparam int GD = 2;

  logic clk = 0, rst_n = 0, cfg_bidir = 0, cfg_expand = 0;
  logic [7:0] out_a = 0, out_b = 0, ded_n = 8'hFF, ext_a = 0, ext_b = 0;
  logic phase;
  logic [7:0] pin_drive, in_a, in_b, in_ded_a, in_ded_b, pin_sense;

  always #(CLK_NS/2) clk = ~clk;

  // board: external pull-downs per phase, wired-OR with block drive
  assign pin_sense = ~(pin_drive | (phase ? ext_b : ext_a));

  mux_io_expander #(.PHASE_CYCLES(PH), .GUARD_CYCLES(GD)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_bidir(cfg_bidir), .cfg_expand(cfg_expand),
    .out_a(out_a), .out_b(out_b), .pin_sense(pin_sense), .ded_n(ded_n),
    .phase(phase), .pin_drive(pin_drive), .in_a(in_a), .in_b(in_b),
    .in_ded_a(in_ded_a), .in_ded_b(in_ded_b));

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_pos = 0;
  logic m_ph = 0;
  logic [7:0] m_drv = 0, m_a = 0, m_b = 0, m_da = 0, m_db = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_ph = 0; m_drv = 0; m_a = 0; m_b = 0; m_da = 0; m_db = 0;
    end else begin
      logic [7:0] low_pins, nd;
      low_pins = m_drv | (m_ph ? ext_b : ext_a);
      nd = m_ph ? ((cfg_bidir || cfg_expand) ? out_b : 8'h00) : out_a;
      if (m_pos == PH - 1) begin
        if (!m_ph) begin
          if (cfg_bidir) m_a = low_pins;
          m_da = ~ded_n;
        end else begin
          if (cfg_bidir) m_b = low_pins;
          if (cfg_expand) m_db = ~ded_n;
        end
      end
      if (m_pos == GD) m_drv = nd;
      if (m_pos == PH - 1) begin m_pos = 0; m_ph = ~m_ph; end
      else m_pos = m_pos + 1;
    end
  end

  // board latches: value on the pins just before each phase edge
  logic prev_ph = 0;
  logic [7:0] prev_low = 0, latch_a = 0, latch_b = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 phase", {7'd0, phase}, {7'd0, m_ph});
      chk("R2 R3 drive", pin_drive, m_drv);
      chk("R4 in_a", in_a, m_a);
      chk("R4 in_b", in_b, m_b);
      chk("R5 in_ded_a", in_ded_a, m_da);
      chk("R6 in_ded_b", in_ded_b, m_db);
      if (phase && !prev_ph) latch_a = prev_low;
      if (!phase && prev_ph) latch_b = prev_low;
    end
    prev_ph = phase;
    prev_low = ~pin_sense;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  int wd = 0;
  logic done = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    chk("R8 reset phase", {7'd0, phase}, 8'h00);
    chk("R8 reset drive", pin_drive, 8'h00);
    chk("R8 reset inputs", in_a | in_b | in_ded_a | in_ded_b, 8'h00);
    rst_n = 1;

    // only bank A outputs, dedicated low bank
    out_a = 8'hA5; out_b = 8'h3C; ded_n = ~8'h0F; ext_a = 8'h00; ext_b = 8'h00;
    cycles(4 * PH);
    chk("R2 latch A", latch_a, 8'hA5);
    chk("R2 bank B released", latch_b, 8'h00);
    chk("R5 ded low bank", in_ded_a, 8'h0F);
    chk("R6 ded high bank held", in_ded_b, 8'h00);
    chk("R4 shared held", in_a, 8'h00);

    // expanded inputs
    cfg_expand = 1; ded_n = ~8'h66;
    cycles(4 * PH);
    chk("R2 latch B", latch_b, 8'h3C);
    chk("R6 ded high bank", in_ded_b, 8'h66);

    // bidirectional, external pulls on released and driven pins
    cfg_expand = 0; cfg_bidir = 1;
    out_a = 8'h81; ext_a = 8'h13; out_b = 8'h01; ext_b = 8'h40;
    cycles(4 * PH);
    chk("R7 latch A OR", latch_a, 8'h93);
    chk("R7 latch B OR", latch_b, 8'h41);
    chk("R7 in_a OR", in_a, 8'h93);
    chk("R7 in_b OR", in_b, 8'h41);
    chk("R9 unmasked input", {7'd0, in_a[1]}, 8'h01);

    // all options, changes mid-phase
    cfg_expand = 1; ded_n = ~8'hC3;
    for (int k = 0; k < 10; k++) begin
      out_a = 8'(k * 37); out_b = 8'(k * 11 + 5);
      ext_a = 8'(k * 3); ext_b = 8'(8'hF0 >> k[2:0]);
      cycles(PH / 2 + k % 3);
    end
    cycles(2 * PH);

    // reset mid-run
    rst_n = 0;
    cycles(2);
    chk("R8 reset mid-run", pin_drive | in_a | in_b | in_ded_a | in_ded_b, 8'h00);
    rst_n = 1;
    cycles(2 * PH);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule